// File: doc/BRIEF.md
# SPI-Controlled UART Register Front End

This block is the device-side command decoder of a UART that a host drives over a four-wire SPI link. The host sends fixed 16-bit full-duplex frames, most significant bit first, while chip select is low. The top two bits of each frame carry the operation. The block keeps the 14-bit UART configuration word and exposes it to the rest of the UART. It accepts received bytes from an external receiver through a one-cycle push strobe and offers bytes to an external transmitter through a valid/ready handshake. It also reports the CTS input and drives the RTS output.

The SPI pins are oversampled in the system clock domain. Chip-select falling starts a frame, and at that instant the block freezes a snapshot of its status. This snapshot feeds the reply shifted out on MISO, which changes after falling SCLK edges. Chip-select rising ends the frame. A frame that saw exactly 16 rising SCLK edges is then executed in a single cycle.

The control FSM has three states:
- ST_IDLE: no frame is open.
- ST_SHIFT: a frame is open.
- ST_EXEC: a completed frame is being applied.

Its transitions are:
- open (ST_IDLE to ST_SHIFT, on chip-select falling).
- commit (ST_SHIFT to ST_EXEC, on chip-select rising after exactly 16 edges).
- abort (ST_SHIFT to ST_IDLE, on chip-select rising after any other edge count).
- retire (ST_EXEC to ST_IDLE; a chip-select falling edge seen in this cycle goes to ST_SHIFT instead).

Bit-level serialisation, baud generation and infrared pulse shaping live elsewhere. The configuration port carries these fields to that logic:
- bits 3:0: baud select. With a 3.6864 MHz oscillator, code 0 is 230400, 1 is 115200, 2 is 57600, 9 is 38400, 10 is 19200, 11 is 9600, 12 is 4800, 13 is 2400, 14 is 1200 and 15 is 600.
- bit 4: word length.
- bit 5: parity enable.
- bit 6: stop bits.
- bit 7: infrared timing.
- bits 11:8: four interrupt masks.
- bit 12: shutdown.
- bit 13: FIFO enable.

Top module: `spiuart_regfront`

## Requirements
- R1: After reset the configuration is 0, tx_valid is 0, rts_n is 1, MISO is 0 while no frame is open, and the first reply reports R=0, T=1.
- R2: A frame is 16 bits, MSB first, sampled on rising SCLK. Bits 15:14 select the operation: 11 writes the configuration, 01 reads it, 10 writes data, 00 reads data. The operation acts when chip select rises.
- R3: A configuration write stores frame bits 13:0 and drives them on `cfg`. A configuration read returns the stored word in reply bits 13:0.
- R4: Reply bit 15 is R (a received byte is held) and bit 14 is T (the transmit holding register is empty). Both are taken when chip select falls, so a change during the frame does not show until the next frame.
- R5: A data-read reply carries the following, with bits 13:11 at 0:
  - bits 7:0: the held byte.
  - bit 8: its parity bit.
  - bit 9: the inverse of cts_n.
  - bit 10: rx_active when configuration bit 12 (shutdown) is 1, otherwise the byte's framing error.
  
  Configuration-write and data-write replies have bits 13:0 at 0.
- R6: A data-read frame whose reply showed R=1 removes the byte (R=0 afterwards). A data-read frame whose reply showed R=0 removes nothing, even if a byte arrived during the frame.
- R7: A data write with bit 10 at 0 and T=1 presents bits 7:0 on tx_data and bit 8 on tx_parity, with tx_valid high, until tx_ready. While tx_valid is high, T reads 0. A data write with bit 10 at 1, or while T=0, queues nothing.
- R8: Every executed data-write frame sets rts_n to the inverse of frame bit 9.
- R9: A frame with a count other than 16 rising SCLK edges has no effect on the configuration, the held byte, the transmitter or rts_n.
- R10: A byte pushed by rx_valid is stored when the holding register is empty, or when it is emptied in the same cycle. A byte pushed while the register is full is dropped and the older byte kept.
- R11: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_parity hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the host |
| miso | output | 1 | SPI reply to the host, 0 outside a frame |
| cfg | output | 14 | Stored configuration word |
| tx_valid | output | 1 | Transmit byte offered to the external transmitter |
| tx_ready | input | 1 | External transmitter accepts the offered byte |
| tx_data | output | 8 | Byte to transmit |
| tx_parity | output | 1 | Parity bit to transmit |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| rx_parity | input | 1 | Received parity bit |
| rx_ferr | input | 1 | Framing error of the received byte |
| rx_active | input | 1 | Receiver line activity, reported in shutdown |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |

## Verification
The bound checker watches these rules on every clock:
- The configuration, rts_n and the holding registers change only in the execute state.
- The frozen R and T snapshot stays put while a frame is shifting.
- An offered transmit byte is held steady until it is accepted.

The bench scenarios show what needs whole frames: the reply bit layout for each operation, the shutdown selection of bit 10, overrun dropping, a byte arriving during a read frame being kept, and short or long frames leaving all state untouched.

// File: rtl/spiuart_pkg.sv
package spiuart_pkg;
    localparam int FRAME_W = 16;
    localparam int CFG_W   = 14;
    localparam int BYTE_W  = 8;

    // reply / frame bit positions that the host decodes
    localparam int POS_PAR  = 8;
    localparam int POS_HS   = 9;
    localparam int POS_X    = 10;
    localparam int POS_SHDN = 12;

    typedef enum logic [1:0] {
        OP_RD_DATA = 2'b00,
        OP_RD_CFG  = 2'b01,
        OP_WR_DATA = 2'b10,
        OP_WR_CFG  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_EXEC  = 2'd2
    } state_e;
endpackage

// File: rtl/spiuart_spi_port.sv
module spiuart_spi_port #(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_BITS  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    input  logic [FRAME_BITS-1:0] reply_word,
    output logic                  cs_fall,
    output logic                  cs_rise,
    output logic                  frame_full,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic [1:0]            cmd,
    output logic                  bit_out
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam int OI_W  = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);

    logic [SYNC_STAGES-1:0] sclk_p, cs_p, mosi_p;
    logic sclk_d, cs_d;
    logic [CNT_W-1:0] cnt;
    logic [OI_W-1:0]  oidx;

    wire sclk_s = sclk_p[SYNC_STAGES-1];
    wire cs_s   = cs_p[SYNC_STAGES-1];
    wire mosi_s = mosi_p[SYNC_STAGES-1];
    wire sclk_rise = sclk_s & ~sclk_d;
    wire sclk_fall = ~sclk_s & sclk_d;

    assign cs_fall    = ~cs_s & cs_d;
    assign cs_rise    = cs_s & ~cs_d;
    assign frame_full = (cnt == CNT_W'(FRAME_BITS));
    assign bit_out    = reply_word[OI_W'(FRAME_BITS - 1) - oidx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
            cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            oidx    <= '0;
            cmd     <= '0;
            rx_word <= '0;
        end else if (cs_fall) begin
            cnt  <= '0;
            oidx <= '0;
            cmd  <= '0;
        end else if (!cs_s) begin
            if (sclk_rise) begin
                rx_word <= {rx_word[FRAME_BITS-2:0], mosi_s};
                if (cnt != CNT_SAT)
                    cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(1))
                    cmd <= {rx_word[0], mosi_s};
            end
            if (sclk_fall && oidx != OI_W'(FRAME_BITS - 1))
                oidx <= oidx + 1'b1;
        end
    end
endmodule

// File: rtl/spiuart_rx_hold.sv
module spiuart_rx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_par,
    input  logic          push_fe,
    input  logic          pop,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          par,
    output logic          fe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            par  <= 1'b0;
            fe   <= 1'b0;
        end else if (push && (!full || pop)) begin
            full <= 1'b1;
            data <= push_data;
            par  <= push_par;
            fe   <= push_fe;
        end else if (pop) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/spiuart_tx_hold.sv
module spiuart_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          load_par,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          par
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            par   <= 1'b0;
        end else if (valid) begin
            if (ready)
                valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
            par   <= load_par;
        end
    end
endmodule

// File: rtl/spiuart_regfront.sv
module spiuart_regfront
    import spiuart_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [CFG_W-1:0]  cfg,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_parity,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_parity,
    input  logic              rx_ferr,
    input  logic              rx_active,
    input  logic              cts_n,
    output logic              rts_n
);
    localparam int PAD_W = CFG_W - BYTE_W - 3;

    state_e state_q, state_d;
    logic cs_fall, cs_rise, frame_full, port_bit;
    logic [FRAME_W-1:0] rx_word, reply_word;
    logic [1:0] cmd_raw;
    logic [CFG_W-1:0] cfg_q, low_bits;

    // status frozen at frame start
    logic snap_r, snap_t, snap_x, snap_hs, snap_par;
    logic [BYTE_W-1:0] snap_data;

    logic hold_full, hold_par, hold_fe;
    logic [BYTE_W-1:0] hold_data;
    logic exec_wcfg, exec_wdat, exec_pop, tx_load;
    op_e op_fin, op_run;

    assign op_fin = op_e'(rx_word[FRAME_W-1 -: 2]);
    assign op_run = op_e'(cmd_raw);

    spiuart_spi_port #(.SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(FRAME_W)) u_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .reply_word(reply_word), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .frame_full(frame_full), .rx_word(rx_word), .cmd(cmd_raw),
        .bit_out(port_bit)
    );

    spiuart_rx_hold #(.DW(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(rx_data),
        .push_par(rx_parity), .push_fe(rx_ferr), .pop(exec_pop),
        .full(hold_full), .data(hold_data), .par(hold_par), .fe(hold_fe)
    );

    spiuart_tx_hold #(.DW(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load),
        .load_data(rx_word[BYTE_W-1:0]), .load_par(rx_word[POS_PAR]),
        .ready(tx_ready), .valid(tx_valid), .data(tx_data), .par(tx_parity)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = ST_SHIFT;                       // open
            ST_SHIFT: if (cs_rise) state_d = frame_full ? ST_EXEC : ST_IDLE; // commit / abort
            ST_EXEC:  state_d = cs_fall ? ST_SHIFT : ST_IDLE;                // retire
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        exec_wcfg = 1'b0;
        exec_wdat = 1'b0;
        exec_pop  = 1'b0;
        tx_load   = 1'b0;
        if (state_q == ST_EXEC) begin
            unique case (op_fin)
                OP_WR_CFG:  exec_wcfg = 1'b1;
                OP_WR_DATA: begin
                    exec_wdat = 1'b1;
                    tx_load   = ~rx_word[POS_X];
                end
                OP_RD_DATA: exec_pop = snap_r;
                OP_RD_CFG:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            rts_n     <= 1'b1;
            snap_r    <= 1'b0;
            snap_t    <= 1'b1;
            snap_x    <= 1'b0;
            snap_hs   <= 1'b0;
            snap_par  <= 1'b0;
            snap_data <= '0;
        end else begin
            if (exec_wcfg) cfg_q <= rx_word[CFG_W-1:0];
            if (exec_wdat) rts_n <= ~rx_word[POS_HS];
            if (cs_fall) begin
                snap_r    <= hold_full;
                snap_t    <= ~tx_valid;
                snap_x    <= cfg_q[POS_SHDN] ? rx_active : hold_fe;
                snap_hs   <= ~cts_n;
                snap_par  <= hold_par;
                snap_data <= hold_data;
            end
        end
    end

    always_comb begin
        unique case (op_run)
            OP_RD_CFG:  low_bits = cfg_q;
            OP_RD_DATA: low_bits = {{PAD_W{1'b0}}, snap_x, snap_hs, snap_par, snap_data};
            default:    low_bits = '0;
        endcase
    end

    assign reply_word = {snap_r, snap_t, low_bits};
    assign miso       = (state_q == ST_SHIFT) ? port_bit : 1'b0;
    assign cfg        = cfg_q;
endmodule

// File: rtl/spiuart_chk.sv
module spiuart_chk
    import spiuart_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input state_e            state,
    input logic [CFG_W-1:0]  cfg,
    input logic              rts_n,
    input logic              rx_full,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_parity,
    input logic              snap_r,
    input logic              snap_t
);
    a_r3_cfg_only_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(state) == ST_EXEC);

    a_r8_rts_only_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rts_n) |-> $past(state) == ST_EXEC);

    a_r6_pop_only_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(state) == ST_EXEC);

    a_r7_load_only_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(state) == ST_EXEC);

    a_r11_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_parity));

    a_r4_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SHIFT && $past(state) == ST_SHIFT |-> $stable(snap_r) && $stable(snap_t));
endmodule

bind spiuart_regfront spiuart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .cfg(cfg), .rts_n(rts_n),
    .rx_full(hold_full), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_parity(tx_parity), .snap_r(snap_r), .snap_t(snap_t)
);

// File: tb/sim_spiuart_regfront.sv
module sim_spiuart_regfront;
    localparam int H = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, tx_valid, tx_parity, rts_n;
    logic tx_ready = 1'b0, rx_valid = 1'b0, rx_parity = 1'b0, rx_ferr = 1'b0;
    logic rx_active = 1'b0, cts_n = 1'b1;
    logic [7:0] rx_data = '0, tx_data;
    logic [13:0] cfg;
    logic [15:0] rep;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spiuart_regfront u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .cfg(cfg), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_parity(tx_parity), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_parity(rx_parity), .rx_ferr(rx_ferr), .rx_active(rx_active),
        .cts_n(cts_n), .rts_n(rts_n)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        rx_data = d;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic xfer(input logic [15:0] w, input int nbits, input int push_at,
                        input logic [7:0] pd, output logic [15:0] r);
        r = '0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_cyc(H);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[15 - i] : 1'b0;
            wait_cyc(H);
            r = {r[14:0], miso};
            sclk = 1'b1;
            if (i == push_at) push(pd);
            wait_cyc(H);
            sclk = 1'b0;
        end
        wait_cyc(H);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_cyc(H + 6);
    endtask

    function automatic logic [15:0] rd_exp(input logic r, input logic t, input logic x,
                                           input logic hs, input logic p, input logic [7:0] d);
        return {r, t, 3'b000, x, hs, p, d};
    endfunction

    task automatic t_reset;
        check("R1 cfg", 32'(cfg), 32'h0);
        check("R1 tx_valid", 32'(tx_valid), 32'h0);
        check("R1 rts_n", 32'(rts_n), 32'h1);
        check("R1 miso idle", 32'(miso), 32'h0);
        xfer(16'h4000, 16, -1, 8'h0, rep);
        check("R1 first reply R/T and cfg", 32'(rep), 32'h4000);
    endtask

    task automatic t_config;
        xfer({2'b11, 14'h2A5B}, 16, -1, 8'h0, rep);
        check("R5 cfg write reply", 32'(rep), 32'h4000);
        check("R3 cfg port", 32'(cfg), 32'h2A5B);
        xfer(16'h4000, 16, -1, 8'h0, rep);
        check("R2 R3 cfg read", 32'(rep), 32'h6A5B);
        xfer({2'b11, 14'h15A4}, 16, -1, 8'h0, rep);
        xfer(16'h4000, 16, -1, 8'h0, rep);
        check("R3 cfg read 2", 32'(rep), 32'h55A4);
        xfer({2'b11, 14'h0001}, 16, -1, 8'h0, rep);
        check("R3 cfg port 2", 32'(cfg), 32'h0001);
    endtask

    task automatic t_receive;
        rx_parity = 1'b1; rx_ferr = 1'b1; cts_n = 1'b0;
        push(8'hA5);
        xfer(16'h0000, 16, -1, 8'h0, rep);
        check("R5 data read normal", 32'(rep), 32'(rd_exp(1, 1, 1, 1, 1, 8'hA5)));
        xfer(16'h0000, 16, -1, 8'h0, rep);
        check("R6 R cleared after pop", 32'(rep[15:14]), 32'h1);
        // shutdown: bit 10 follows rx_active
        xfer({2'b11, 14'h1000}, 16, -1, 8'h0, rep);
        rx_parity = 1'b0; rx_ferr = 1'b0; cts_n = 1'b1; rx_active = 1'b1;
        push(8'h3C);
        xfer(16'h0000, 16, -1, 8'h0, rep);
        check("R5 data read shutdown", 32'(rep), 32'(rd_exp(1, 1, 1, 0, 0, 8'h3C)));
        rx_active = 1'b0;
        xfer({2'b11, 14'h0000}, 16, -1, 8'h0, rep);
    endtask

    task automatic t_overrun;
        push(8'h11);
        push(8'h22);
        xfer(16'h0000, 16, -1, 8'h0, rep);
        check("R10 older byte kept", 32'(rep), 32'(rd_exp(1, 1, 0, 0, 0, 8'h11)));
    endtask

    task automatic t_midframe;
        xfer(16'h0000, 16, 3, 8'h5A, rep);
        check("R4 R frozen at frame start", 32'(rep[15:14]), 32'h1);
        xfer(16'h0000, 16, -1, 8'h0, rep);
        check("R6 mid-frame byte kept", 32'(rep), 32'(rd_exp(1, 1, 0, 0, 0, 8'h5A)));
    endtask

    task automatic t_transmit;
        xfer(16'h833C, 16, -1, 8'h0, rep);
        check("R5 data write reply", 32'(rep), 32'h4000);
        check("R7 tx_valid", 32'(tx_valid), 32'h1);
        check("R7 tx_data/parity", 32'({tx_parity, tx_data}), 32'h13C);
        check("R8 rts_n low", 32'(rts_n), 32'h0);
        xfer(16'h4000, 16, -1, 8'h0, rep);
        check("R4 T=0 while busy", 32'(rep), 32'h0000);
        xfer(16'h8077, 16, -1, 8'h0, rep);
        check("R7 write while busy dropped", 32'({tx_valid, tx_parity, tx_data}), 32'h33C);
        check("R8 rts_n high", 32'(rts_n), 32'h1);
        @(negedge clk) tx_ready = 1'b1;
        @(negedge clk) tx_ready = 1'b0;
        check("R7 accepted", 32'(tx_valid), 32'h0);
        xfer(16'h4000, 16, -1, 8'h0, rep);
        check("R4 T=1 after accept", 32'(rep), 32'h4000);
        xfer(16'h8655, 16, -1, 8'h0, rep);
        check("R7 disabled write not queued", 32'(tx_valid), 32'h0);
        check("R8 rts_n from disabled write", 32'(rts_n), 32'h0);
    endtask

    task automatic t_short;
        xfer({2'b11, 14'h0ABC}, 12, -1, 8'h0, rep);
        check("R9 12-bit cfg write ignored", 32'(cfg), 32'h0);
        xfer({2'b11, 14'h0ABC}, 15, -1, 8'h0, rep);
        check("R9 15-bit cfg write ignored", 32'(cfg), 32'h0);
        xfer({2'b11, 14'h0ABC}, 17, -1, 8'h0, rep);
        check("R9 17-bit cfg write ignored", 32'(cfg), 32'h0);
        xfer(16'h8200, 10, -1, 8'h0, rep);
        check("R9 short data write", 32'({tx_valid, rts_n}), 32'h0);
        push(8'h66);
        xfer(16'h0000, 8, -1, 8'h0, rep);
        xfer(16'h0000, 16, -1, 8'h0, rep);
        check("R9 short read did not pop", 32'(rep), 32'(rd_exp(1, 1, 0, 0, 0, 8'h66)));
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);
        t_reset;
        t_config;
        t_receive;
        t_overrun;
        t_midframe;
        t_transmit;
        t_short;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule